// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Dead Time and Bootstrap Precharge

This block turns one PWM command into a pair of gate enables for one half-bridge leg: a high-side enable and a low-side enable that are never on together. Each change of side passes through a dead interval in which both enables are low. The interval is either a counted delay taken from a configuration code, or an adaptive wait that ends when a feedback bit reports that the gate just released has actually fallen low. A timeout bounds the adaptive wait. When it expires, the leg is parked with both enables low and a fault is held until reset.

The block also manages the bootstrap supply of the high-side driver. In step-down (buck) operation with the bootstrap undervoltage flag raised, the high side is kept off. Each PWM period then produces a single short low-side pulse that recharges the bootstrap capacitor instead of normal switching. Normal complementary switching returns once the flag clears. In step-up (boost) operation the flag is ignored, because the regular low-side conduction recharges the supply anyway.

Top module: `hb_gate_seq`

## Requirements
- R1: `ho_en` and `lo_en` are never high in the same cycle.
- R2: In counted mode (`dt_adaptive`=0), both enables stay low for exactly `ceil(T / CLK_NS)` cycles between one side turning off and the other turning on. T is `dt_code` × 2.625 ns, limited to the range 15 ns to 200 ns. This holds in both directions.
- R3: In adaptive mode (`dt_adaptive`=1), the high side turns on only on the edge after `lo_gate_low` is seen high, and the low side only on the edge after `ho_gate_low` is seen high. The dead interval is therefore at least one cycle.
- R4: In adaptive mode, if the awaited feedback is still low after `TO_CYC` cycles of dead interval, `fault` rises and both enables stay low regardless of PWM until reset.
- R5: In buck mode (`boost_mode`=0) with `boot_uv`=1, `ho_en` stays low. Each rising edge of `pwm_in` yields one `lo_en` pulse of `ceil(PRE_NS / CLK_NS)` cycles, which starts after the programmed dead interval.
- R6: If `boot_uv` rises while the high side is on in buck mode, `ho_en` drops on the next clock edge.
- R7: In buck mode, when `boot_uv` clears, normal complementary switching resumes following the PWM level, with a dead interval ahead of the first turn-on.
- R8: In boost mode (`boost_mode`=1), `boot_uv` has no effect and no precharge pulses appear.
- R9: `boost_mode`, `dt_adaptive` and `dt_code` are taken in only while both enables are low: continuously while the sequencer is idle, and at the edge where an enable turns off. Changes made while an enable is on, or during a dead interval already running, do not affect that interval or the side that is on.
- R10: Synchronous active-high `rst` sets `ho_en`, `lo_en` and `fault` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, period `CLK_NS` ns |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM command: 1 asks for the high side, 0 for the low side |
| boost_mode | input | 1 | 1 = boost operation, 0 = buck operation |
| dt_adaptive | input | 1 | 1 = adaptive dead time, 0 = counted dead time |
| dt_code | input | CODE_W | Dead-time code, 2.625 ns per step |
| boot_uv | input | 1 | Bootstrap supply below its threshold |
| ho_gate_low | input | 1 | High-side gate observed below its low threshold |
| lo_gate_low | input | 1 | Low-side gate observed below its low threshold |
| ho_en | output | 1 | High-side gate enable (registered) |
| lo_en | output | 1 | Low-side gate enable (registered) |
| fault | output | 1 | Adaptive feedback timeout, held until reset |

## Verification
The bench sweeps every dead-time code in both switching directions and compares the gap with the rounded, clamped value it computes itself. This exposes a missing clamp at either end, rounding down instead of up, or an off-by-one in the counter. It changes the code and the mode while a side is on or the dead interval is already counting, so a design that re-reads its configuration at the wrong time shows a shortened gap or a high side that drops out. It measures the precharge pulses: count, start cycle and width, with the high side silent. It also checks that the high side is cut on the very next edge when the bootstrap flag rises, and that boost mode ignores the flag. In adaptive mode it withholds feedback for several cycles and then for the full timeout, which catches a design that turns on without the feedback, one whose timeout is off by a cycle, and one that lets the fault clear itself.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEAD  = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_PRE   = 3'd4,
    ST_FAULT = 3'd5
  } seq_st_t;

  typedef enum logic [1:0] {
    TG_HIGH = 2'd0,
    TG_LOW  = 2'd1,
    TG_PRE  = 2'd2
  } seq_tgt_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/hb_pwm_edge.sv
module hb_pwm_edge (
  input  logic clk,
  input  logic rst,
  input  logic pwm_in,
  output logic pwm_rise
);
  logic pwm_q;

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= pwm_in;
  end

  assign pwm_rise = pwm_in & ~pwm_q;
endmodule

// File: rtl/hb_dt_calc.sv
// Converts a dead-time code into clock cycles: code * STEP_PS, limited to
// [MIN_PS, MAX_PS], rounded up to whole clock periods.
module hb_dt_calc #(
  parameter int CLK_NS  = 10,
  parameter int CODE_W  = 8,
  parameter int OUT_W   = 5,
  parameter int STEP_PS = 2625,
  parameter int MIN_PS  = 15000,
  parameter int MAX_PS  = 200000
) (
  input  logic [CODE_W-1:0] code,
  output logic [OUT_W-1:0]  cycles
);
  localparam int CLK_PS = CLK_NS * 1000;

  logic [31:0] raw_ps;
  logic [31:0] lim_ps;
  logic [31:0] cyc_full;

  always_comb begin
    raw_ps = 32'(code) * 32'(STEP_PS);
    if (raw_ps < 32'(MIN_PS))      lim_ps = 32'(MIN_PS);
    else if (raw_ps > 32'(MAX_PS)) lim_ps = 32'(MAX_PS);
    else                           lim_ps = raw_ps;
    cyc_full = (lim_ps + 32'(CLK_PS - 1)) / 32'(CLK_PS);
    cycles   = OUT_W'(cyc_full);
  end
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_seq_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int CODE_W = 8,
  parameter int PRE_NS = 100,
  parameter int TO_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwm_in,
  input  logic              boost_mode,
  input  logic              dt_adaptive,
  input  logic [CODE_W-1:0] dt_code,
  input  logic              boot_uv,
  input  logic              ho_gate_low,
  input  logic              lo_gate_low,
  output logic              ho_en,
  output logic              lo_en,
  output logic              fault
);
  localparam int CLK_PS     = CLK_NS * 1000;
  localparam int DT_MAX_CYC = ceil_div(200000, CLK_PS);
  localparam int PRE_CYC    = ceil_div(PRE_NS * 1000, CLK_PS);
  localparam int CNT_MAX    = max3(DT_MAX_CYC, PRE_CYC, TO_CYC);
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  seq_st_t           st, st_n;
  seq_tgt_t          tgt, tgt_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              ho_n, lo_n, fault_n, cap;
  logic              cfg_boost_q, cfg_adapt_q;
  logic [CODE_W-1:0] cfg_code_q;
  logic [CNT_W-1:0]  dt_cyc;
  logic              pwm_rise;
  logic              fb_ok, dead_done, hold_off;

  hb_pwm_edge edge_i (
    .clk      (clk),
    .rst      (rst),
    .pwm_in   (pwm_in),
    .pwm_rise (pwm_rise)
  );

  hb_dt_calc #(
    .CLK_NS (CLK_NS),
    .CODE_W (CODE_W),
    .OUT_W  (CNT_W)
  ) dt_i (
    .code   (cfg_code_q),
    .cycles (dt_cyc)
  );

  // Buck with a weak bootstrap: high side must stay off.
  assign hold_off  = ~cfg_boost_q & boot_uv;
  assign fb_ok     = (tgt == TG_HIGH) ? lo_gate_low : ho_gate_low;
  assign dead_done = cfg_adapt_q ? fb_ok : (cnt == dt_cyc - CNT_W'(1));

  always_comb begin
    st_n    = st;
    tgt_n   = tgt;
    cnt_n   = cnt;
    ho_n    = ho_en;
    lo_n    = lo_en;
    fault_n = fault;
    cap     = 1'b0;
    case (st)
      ST_IDLE: begin
        cap = 1'b1;
        if (!boost_mode && boot_uv) begin
          if (pwm_rise) begin
            st_n  = ST_DEAD;
            tgt_n = TG_PRE;
            cnt_n = '0;
          end
        end else begin
          st_n  = ST_DEAD;
          tgt_n = pwm_in ? TG_HIGH : TG_LOW;
          cnt_n = '0;
        end
      end
      ST_DEAD: begin
        if (dead_done) begin
          cnt_n = '0;
          case (tgt)
            TG_HIGH: if (hold_off) st_n = ST_IDLE;
                     else begin st_n = ST_HIGH; ho_n = 1'b1; end
            TG_LOW:  if (hold_off) st_n = ST_IDLE;
                     else begin st_n = ST_LOW; lo_n = 1'b1; end
            default: begin st_n = ST_PRE; lo_n = 1'b1; end
          endcase
        end else if (cfg_adapt_q && cnt == CNT_W'(TO_CYC - 1)) begin
          st_n    = ST_FAULT;
          fault_n = 1'b1;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      ST_HIGH: begin
        if (hold_off) begin
          ho_n = 1'b0;
          st_n = ST_IDLE;
        end else if (!pwm_in) begin
          ho_n  = 1'b0;
          st_n  = ST_DEAD;
          tgt_n = TG_LOW;
          cnt_n = '0;
          cap   = 1'b1;
        end
      end
      ST_LOW: begin
        if (hold_off) begin
          lo_n = 1'b0;
          st_n = ST_IDLE;
        end else if (pwm_in) begin
          lo_n  = 1'b0;
          st_n  = ST_DEAD;
          tgt_n = TG_HIGH;
          cnt_n = '0;
          cap   = 1'b1;
        end
      end
      ST_PRE: begin
        if (cnt == CNT_W'(PRE_CYC - 1)) begin
          lo_n  = 1'b0;
          st_n  = ST_IDLE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      default: begin
        ho_n    = 1'b0;
        lo_n    = 1'b0;
        fault_n = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      tgt         <= TG_LOW;
      cnt         <= '0;
      ho_en       <= 1'b0;
      lo_en       <= 1'b0;
      fault       <= 1'b0;
      cfg_boost_q <= 1'b0;
      cfg_adapt_q <= 1'b0;
      cfg_code_q  <= '0;
    end else begin
      st    <= st_n;
      tgt   <= tgt_n;
      cnt   <= cnt_n;
      ho_en <= ho_n;
      lo_en <= lo_n;
      fault <= fault_n;
      if (cap) begin
        cfg_boost_q <= boost_mode;
        cfg_adapt_q <= dt_adaptive;
        cfg_code_q  <= dt_code;
      end
    end
  end
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk (
  input logic clk,
  input logic rst,
  input logic ho_en,
  input logic lo_en,
  input logic fault,
  input logic boot_uv,
  input logic ho_gate_low,
  input logic lo_gate_low,
  input logic cfg_boost,
  input logic cfg_adapt
);
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(ho_en && lo_en));

  a_r2_gap_before_ho: assert property (@(posedge clk) disable iff (rst)
    $rose(ho_en) |-> !$past(lo_en));

  a_r2_gap_before_lo: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_en) |-> !$past(ho_en));

  a_r3_ho_waits_fb: assert property (@(posedge clk) disable iff (rst)
    ($rose(ho_en) && $past(cfg_adapt)) |-> $past(lo_gate_low));

  a_r3_lo_waits_fb: assert property (@(posedge clk) disable iff (rst)
    ($rose(lo_en) && $past(cfg_adapt)) |-> $past(ho_gate_low));

  a_r4_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!ho_en && !lo_en));

  a_r4_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  a_r6_ho_cut: assert property (@(posedge clk) disable iff (rst)
    (boot_uv && !cfg_boost) |=> !ho_en);
endmodule

bind hb_gate_seq hb_gate_seq_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .ho_en       (ho_en),
  .lo_en       (lo_en),
  .fault       (fault),
  .boot_uv     (boot_uv),
  .ho_gate_low (ho_gate_low),
  .lo_gate_low (lo_gate_low),
  .cfg_boost   (cfg_boost_q),
  .cfg_adapt   (cfg_adapt_q)
);

// File: tb/hb_gate_seq_tb_top.sv
module hb_gate_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 8;
  localparam int TO_CYC     = 16;
  localparam int PRE_W      = (100 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_in = 1'b0, boost_mode = 1'b1, dt_adaptive = 1'b0;
  logic [CODE_W-1:0] dt_code = '0;
  logic boot_uv = 1'b0, ho_gate_low = 1'b1, lo_gate_low = 1'b1;
  logic ho_en, lo_en, fault;

  int total = 0;
  int passed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hb_gate_seq #(.CLK_NS(CLK_PERIOD), .CODE_W(CODE_W), .PRE_NS(100), .TO_CYC(TO_CYC)) dut_i (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .boost_mode(boost_mode),
    .dt_adaptive(dt_adaptive), .dt_code(dt_code), .boot_uv(boot_uv),
    .ho_gate_low(ho_gate_low), .lo_gate_low(lo_gate_low),
    .ho_en(ho_en), .lo_en(lo_en), .fault(fault)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_dt(input int code);
    int ps;
    ps = code * 2625;
    if (ps < 15000) ps = 15000;
    if (ps > 200000) ps = 200000;
    return (ps + CLK_PERIOD * 1000 - 1) / (CLK_PERIOD * 1000);
  endfunction

  // Drive a new PWM level and count cycles with both enables low.
  task automatic gap(input logic lvl, output int off);
    pwm_in = lvl;
    @(negedge clk);
    off = 0;
    while (!ho_en && !lo_en && off < 300) begin
      off++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  initial begin
    int off, lo_cnt, ho_cnt, first;
    wait_n(3);
    chk(!ho_en && !lo_en && !fault, "R10 reset state", {ho_en, lo_en, fault}, 0);
    rst = 1'b0;
    wait_n(10);

    // R2: exhaustive code sweep, both directions
    for (int code = 0; code < (1 << CODE_W); code++) begin
      dt_code = CODE_W'(code);
      gap(1'b1, off);
      chk(off == exp_dt(code) && ho_en, $sformatf("R2 lo->ho code %0d", code), off, exp_dt(code));
      wait_n(3);
      gap(1'b0, off);
      chk(off == exp_dt(code) && lo_en, $sformatf("R2 ho->lo code %0d", code), off, exp_dt(code));
      wait_n(3);
    end

    // R9: code change during a running dead interval is ignored
    dt_code = 8'd76;
    pwm_in = 1'b1;
    wait_n(25);
    pwm_in = 1'b0;
    @(negedge clk);
    off = 0;
    while (!ho_en && !lo_en && off < 300) begin
      off++;
      if (off == 3) dt_code = 8'd0;
      @(negedge clk);
    end
    chk(off == exp_dt(76), "R9 code held in dead interval", off, exp_dt(76));
    wait_n(25);

    // R6: enter buck, then bootstrap flag cuts HO on the next edge
    boost_mode = 1'b0;
    pwm_in = 1'b1;
    wait_n(25);
    chk(ho_en == 1'b1, "R6 ho on before flag", ho_en, 1);
    boot_uv = 1'b1;
    @(negedge clk);
    chk(ho_en == 1'b0, "R6 ho cut next edge", ho_en, 0);
    pwm_in = 1'b0;
    wait_n(20);

    // R5: three precharge periods
    for (int p = 0; p < 3; p++) begin
      lo_cnt = 0; ho_cnt = 0; first = 0;
      pwm_in = 1'b1;
      for (int i = 1; i <= 40; i++) begin
        if (i == 21) pwm_in = 1'b0;
        @(negedge clk);
        if (lo_en) begin lo_cnt++; if (first == 0) first = i; end
        if (ho_en) ho_cnt++;
      end
      chk(lo_cnt == PRE_W, "R5 pulse width", lo_cnt, PRE_W);
      chk(first == exp_dt(0) + 1, "R5 pulse start", first, exp_dt(0) + 1);
      chk(ho_cnt == 0, "R5 ho held off", ho_cnt, 0);
    end

    // R7: flag clears with PWM high
    pwm_in = 1'b1;
    wait_n(20);
    boot_uv = 1'b0;
    wait_n(2);
    chk(ho_en == 1'b0, "R7 dead interval before ho", ho_en, 0);
    @(negedge clk);
    chk(ho_en == 1'b1 && lo_en == 1'b0, "R7 ho resumes", ho_en, 1);
    pwm_in = 1'b0;
    wait_n(5);
    chk(lo_en == 1'b1, "R7 lo resumes", lo_en, 1);

    // R8: boost ignores the flag
    boost_mode = 1'b1;
    pwm_in = 1'b1;
    wait_n(10);
    boot_uv = 1'b1;
    wait_n(3);
    chk(ho_en == 1'b1, "R8 ho stays on", ho_en, 1);
    pwm_in = 1'b0;
    wait_n(5);
    chk(lo_en == 1'b1 && ho_en == 1'b0, "R8 normal low side", lo_en, 1);
    pwm_in = 1'b1;
    wait_n(5);
    chk(ho_en == 1'b1, "R8 normal high side", ho_en, 1);

    // R9: mode change while HO is on waits for the next off edge
    boost_mode = 1'b0;
    wait_n(4);
    chk(ho_en == 1'b1, "R9 mode held while on", ho_en, 1);
    pwm_in = 1'b0;
    wait_n(6);
    chk(!ho_en && !lo_en, "R9 buck applied after off", {ho_en, lo_en}, 0);
    boot_uv = 1'b0;
    wait_n(6);
    chk(lo_en == 1'b1, "R9 lo after flag clear", lo_en, 1);

    // R3: adaptive wait for feedback
    dt_adaptive = 1'b1;
    lo_gate_low = 1'b0;
    pwm_in = 1'b1;
    @(negedge clk);
    chk(!lo_en && !ho_en, "R3 lo released", {ho_en, lo_en}, 0);
    ho_cnt = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (ho_en) ho_cnt++;
    end
    chk(ho_cnt == 0, "R3 ho waits for feedback", ho_cnt, 0);
    lo_gate_low = 1'b1;
    @(negedge clk);
    chk(ho_en == 1'b1, "R3 ho after feedback", ho_en, 1);
    wait_n(3);
    gap(1'b0, off);
    chk(off == 1 && lo_en, "R3 immediate feedback gap", off, 1);
    wait_n(3);

    // R4: timeout
    lo_gate_low = 1'b0;
    pwm_in = 1'b1;
    wait_n(TO_CYC);
    chk(fault == 1'b0, "R4 no fault before timeout", fault, 0);
    @(negedge clk);
    chk(fault == 1'b1 && !ho_en && !lo_en, "R4 fault at timeout", fault, 1);
    lo_gate_low = 1'b1;
    ho_cnt = 0; lo_cnt = 0;
    for (int i = 0; i < 80; i++) begin
      if (i % 20 == 0) pwm_in = ~pwm_in;
      @(negedge clk);
      if (ho_en) ho_cnt++;
      if (lo_en) lo_cnt++;
    end
    chk(ho_cnt == 0 && lo_cnt == 0, "R4 outputs parked", ho_cnt + lo_cnt, 0);
    chk(fault == 1'b1, "R4 fault held", fault, 1);

    // R10: reset clears the fault
    rst = 1'b1;
    wait_n(2);
    chk(!ho_en && !lo_en && !fault, "R10 reset clears", {ho_en, lo_en, fault}, 0);
    rst = 1'b0;
    wait_n(2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule